// File: doc/BRIEF.md
# Per-Destination Injection Spacer

This block sits between a packet source and the injection port of a network router. Every incoming packet carries a destination index. The block enforces a minimum spacing, counted in clock cycles, between two injections to the same destination. A packet that may not leave yet waits in a small queue that belongs to its destination. Traffic to any other destination keeps flowing while it waits.

Each destination has its own queue and its own countdown. A destination is eligible when its queue holds a packet and its countdown has reached zero. A round-robin arbiter picks one eligible destination per cycle. Both the input side and the output side use valid/ready handshakes. An accepted packet can leave on the next clock edge at the earliest.

Top module: `inj_spacer`

## Requirements
- R1: During reset and after it, `out_valid_o` is 0, and `in_ready_o` is 1 for every destination index.
- R2: Take a packet to a destination that has never been served, or whose spacing has run out. If it is accepted at edge e and is the only eligible packet with `out_ready_i` high, it is injected at edge e+1.
- R3: Two injections to the same destination are at least `GAP` edges apart (default 20). The countdown restarts from every injection to that destination. A packet already queued behind the previous one is injected exactly `GAP` edges after it, provided nothing else is granted ahead of it.
- R4: While one destination is waiting for its spacing, packets to other destinations are injected without delay.
- R5: Packets to the same destination leave in the order they were accepted.
- R6: `in_ready_o` is 0 exactly when the queue of the destination on `in_dest_i` holds `DEPTH` packets. It is independent of the other queues. A packet offered while `in_ready_o` is 0 is not stored and never appears at the output.
- R7: When several destinations are eligible, the grant goes to the first one found by searching upward from (last granted index + 1) modulo `NUM_DEST`, wrapping round. At most one packet is injected per cycle.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, on the next cycle `out_valid_o` stays 1 and `out_dest_o` and `out_data_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Source offers a packet |
| in_ready_o | output | 1 | Queue of the offered destination has room |
| in_dest_i | input | DEST_W | Destination index of the offered packet |
| in_data_i | input | DATA_W | Packet payload |
| out_valid_o | output | 1 | A packet is presented to the router |
| out_ready_i | input | 1 | Router accepts the presented packet |
| out_dest_o | output | DEST_W | Destination index of the presented packet |
| out_data_o | output | DATA_W | Payload of the presented packet |

## Verification
The hardest case to reach from the ports is a contention in which a fixed-priority arbiter and a round-robin arbiter would choose differently. Two destinations only become eligible in the same cycle when one countdown expires on exactly the edge where a fresh packet to a second destination lands. The stimulus table therefore times an arrival for destination 3 one edge before the queued packet for destination 0 finishes its spacing, with the rotation pointer sitting at 3. The queue-full and stall-hold cases are reached in a second phase. There the router side is held not ready while one destination's queue is filled to the limit and then offered one more packet.

// File: rtl/spacer_pkg.sv
package spacer_pkg;
  // index width that never collapses to zero
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int cnt_w(input int n);
    return (n > 0) ? $clog2(n + 1) : 1;
  endfunction
endpackage

// File: rtl/spacer_fifo.sv
module spacer_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = spacer_pkg::idx_w(DEPTH);
  localparam int CNT_W = spacer_pkg::cnt_w(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && empty_o)); // R5
endmodule

// File: rtl/spacer_gap_timer.sv
module spacer_gap_timer #(
  parameter int GAP = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic open_o
);
  localparam int CNT_W = spacer_pkg::cnt_w(GAP);

  logic [CNT_W-1:0] cnt_q;

  assign open_o = (cnt_q == '0);

  // load GAP-1 on a send: next send lands GAP edges later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (fire_i)        cnt_q <= CNT_W'(GAP - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  AST_GAP_RESPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> (cnt_q == '0)); // R3
endmodule

// File: rtl/spacer_rr_arb.sv
module spacer_rr_arb #(
  parameter int N = 4,
  localparam int IDX_W = spacer_pkg::idx_w(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             hold_i,
  input  logic             adv_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q, lock_idx_q, pick_idx;
  logic             lock_q, pick_valid;
  int               cand;

  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    cand       = 0;
    // scan farthest first so the nearest match from the pointer wins
    for (int i = N - 1; i >= 0; i--) begin
      cand = (int'(ptr_q) + i) % N;
      if (req_i[IDX_W'(cand)]) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'(cand);
      end
    end
  end

  assign gnt_valid_o = lock_q | pick_valid;
  assign gnt_idx_o   = lock_q ? lock_idx_q : pick_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else if (adv_i) begin
      ptr_q  <= (gnt_idx_o == IDX_W'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
      lock_q <= 1'b0;
    end else if (hold_i) begin
      lock_q     <= 1'b1;
      lock_idx_q <= gnt_idx_o;
    end
  end

  AST_GNT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> req_i[gnt_idx_o]); // R7
  AST_ADV_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> gnt_valid_o); // R7
endmodule

// File: rtl/inj_spacer.sv
module inj_spacer #(
  parameter int NUM_DEST = 4,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4,
  parameter int GAP      = 20,
  localparam int DEST_W  = spacer_pkg::idx_w(NUM_DEST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DEST_W-1:0] in_dest_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DEST_W-1:0] out_dest_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic [NUM_DEST-1:0] push, pop, empty, full, open, elig;
  logic [DATA_W-1:0]   head [NUM_DEST];
  logic                dest_ok, fire, gnt_valid;
  logic [DEST_W-1:0]   gnt_idx;

  assign dest_ok    = (32'(in_dest_i) < NUM_DEST);
  assign in_ready_o = dest_ok && !full[in_dest_i];
  assign fire       = out_valid_o && out_ready_i;

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
    assign push[d] = in_valid_i && in_ready_o && (in_dest_i == DEST_W'(d));
    assign pop[d]  = fire && (gnt_idx == DEST_W'(d));
    assign elig[d] = !empty[d] && open[d];

    spacer_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[d]),
      .data_i  (in_data_i),
      .pop_i   (pop[d]),
      .head_o  (head[d]),
      .empty_o (empty[d]),
      .full_o  (full[d])
    );

    spacer_gap_timer #(.GAP(GAP)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (pop[d]),
      .open_o (open[d])
    );
  end

  spacer_rr_arb #(.N(NUM_DEST)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (elig),
    .hold_i      (out_valid_o && !out_ready_i),
    .adv_i       (fire),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  assign out_valid_o = gnt_valid;
  assign out_dest_o  = gnt_idx;
  assign out_data_o  = head[gnt_idx];

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_dest_o) && $stable(out_data_o))); // R8
  AST_SINGLE_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop)); // R7
  AST_ELIG_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|elig) |-> out_valid_o); // R4
endmodule

// File: tb/inj_spacer_tb_top.sv
module inj_spacer_tb_top;
  localparam int N = 4, DW = 8, DEP = 4, GAP = 20, NV = 10, MAXOFF = 60;

  // {push offset, dest, data, expected inject offset, requirement}
  localparam int VEC [NV][5] = '{
    '{ 0, 0, 'hA0,  1, 2},  // R2 fresh destination
    '{ 1, 0, 'hA1, 22, 7},  // R7 loses edge 21 to dest 3
    '{ 2, 1, 'hB0,  3, 4},  // R4 not held by dest 0
    '{ 3, 0, 'hA2, 42, 3},  // R3 restart from edge 22
    '{ 4, 2, 'hC0,  5, 4},  // R4
    '{ 5, 1, 'hB1, 23, 3},  // R3
    '{20, 3, 'hD0, 21, 7},  // R7 pointer at 3 beats dest 0
    '{30, 2, 'hC1, 31, 4},  // R4
    '{31, 2, 'hC2, 51, 3},  // R3 exact gap when queued
    '{41, 1, 'hB2, 43, 7}   // R7 pointer at 3 picks 0 first
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [1:0] in_dest = 0, out_dest;
  logic [DW-1:0] in_data = 0, out_data;

  int checks = 0, fails = 0, edge_cnt = 0, n_log = 0, base = 0;
  int log_edge [64];
  int log_dest [64];
  int log_data [64];
  bit done = 0;

  always #10 clk = ~clk;

  inj_spacer #(.NUM_DEST(N), .DATA_W(DW), .DEPTH(DEP), .GAP(GAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_dest_i(in_dest), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_dest_o(out_dest), .out_data_o(out_data)
  );

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && n_log < 64) begin
      log_edge[n_log] = edge_cnt + 1;
      log_dest[n_log] = int'(out_dest);
      log_data[n_log] = int'(out_data);
      n_log++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int k0, k, s;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 valid after reset", int'(out_valid), 0);
    for (int d = 0; d < N; d++) begin
      in_dest = 2'(d);
      #1 chk(in_ready == 1, "R1 ready after reset", int'(in_ready), 1);
    end
    @(negedge clk);

    // table phase
    base = edge_cnt + 1;
    for (int off = 0; off <= MAXOFF; off++) begin
      in_valid = 0;
      for (int v = 0; v < NV; v++) begin
        if (VEC[v][0] == off) begin
          in_valid = 1; in_dest = 2'(VEC[v][1]); in_data = DW'(VEC[v][2]);
        end
      end
      #1 if (in_valid) chk(in_ready == 1, "R6 ready while room", int'(in_ready), 1);
      @(negedge clk);
    end
    in_valid = 0;
    for (int v = 0; v < NV; v++) begin
      k = -1;
      for (int j = 0; j < n_log; j++) if (log_data[j] == VEC[v][2]) k = j;
      chk(k >= 0, $sformatf("R%0d packet present", VEC[v][4]), k, 0);
      if (k >= 0) begin
        chk(log_dest[k] == VEC[v][1], $sformatf("R%0d dest", VEC[v][4]), log_dest[k], VEC[v][1]);
        chk(log_edge[k] - base == VEC[v][3], $sformatf("R%0d inject edge", VEC[v][4]),
            log_edge[k] - base, VEC[v][3]);
      end
    end
    chk(n_log == NV, "R7 one packet per grant", n_log, NV);

    // full queue, stall hold, order
    out_ready = 0;
    for (int i = 0; i < DEP; i++) begin
      in_valid = 1; in_dest = 2'd3; in_data = DW'('h30 + i);
      #1 chk(in_ready == 1, "R6 ready before full", int'(in_ready), 1);
      @(negedge clk);
    end
    in_valid = 0; in_dest = 2'd3;
    #1 chk(in_ready == 0, "R6 ready low when full", int'(in_ready), 0);
    in_dest = 2'd2;
    #1 chk(in_ready == 1, "R6 other dest unaffected", int'(in_ready), 1);
    in_valid = 1; in_dest = 2'd3; in_data = 8'h34;
    @(negedge clk);
    in_valid = 0;
    for (int i = 0; i < 3; i++) begin
      chk(out_valid == 1, "R8 valid held", int'(out_valid), 1);
      chk(out_dest == 2'd3, "R8 dest held", int'(out_dest), 3);
      chk(out_data == 8'h30, "R8 data held", int'(out_data), 'h30);
      @(negedge clk);
    end
    k0 = n_log;
    out_ready = 1;
    repeat (DEP * GAP + 10) @(negedge clk);
    chk(n_log == k0 + DEP, "R6 rejected packet absent", n_log - k0, DEP);
    s = log_edge[k0];
    for (int i = 0; i < DEP; i++) begin
      chk(log_data[k0 + i] == 'h30 + i, "R5 same-dest order", log_data[k0 + i], 'h30 + i);
      chk(log_edge[k0 + i] - s == i * GAP, "R3 queued spacing", log_edge[k0 + i] - s, i * GAP);
    end
    finish_run();
  end
endmodule